// File: doc/BRIEF.md
# Register-Mapped MDIO Management Controller

This block lets software reach the management registers of an external Ethernet PHY over a two-wire serial management bus. It decodes five 32-bit registers on a simple write-strobe bus: an address word, a write-data word, a control word, a status word and a read-data word. Software loads the target PHY number and register number into the address word. For a write it also loads the 16-bit value. It then sets one request bit in the control word and polls the busy flag in the status word until it drops.

On an accepted request the controller serialises a clause-22 management frame on MDIO. The management clock is divided down from the system clock. For a read, the controller releases the MDIO line at the turnaround, shifts in the PHY's 16 data bits, and presents them in the read-data word when the frame ends. Request bits are consumed on the cycle they are written. A request written while a frame is running has no effect.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status word and the read-data word read 0, MDC is low and the MDIO output enable is low.
- R2: The address word (offset 0x218) keeps the PHY number in bits 12:8 and the register number in bits 4:0. The write-data word (offset 0x21C) keeps its low 16 bits. All other bits of both words read 0.
- R3: In the control word (offset 0x214), bit 3 requests a read and bit 2 requests a write. Bit 3 wins when both are set. A control write with neither bit set starts nothing. The control word always reads 0, because requests clear themselves once accepted.
- R4: Status bit 0 (offset 0x220) reads 1 from the cycle after an accepted request and stays 1 for exactly 128 × DIV_HALF system clocks. It then reads 0.
- R5: A write frame is 64 bits, sent MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY number, the 5-bit register number, turnaround 10, then the 16 data bits. The output enable is high for all 64 bits.
- R6: A read frame uses opcode 10. The output enable drops from bit 46 (the first turnaround bit) to the end of the frame. The 16 bits sampled in frame positions 48 to 63 appear MSB first in bits 15:0 of the read-data word (offset 0x224), and bits 31:16 read 0. A write frame leaves the read-data word unchanged.
- R7: MDC has a period of 2 × DIV_HALF system clocks and is low while idle. MDIO changes only after a falling MDC edge, and the PHY samples it on the rising edge.
- R8: A request written while busy is ignored: the running frame is neither restarted nor extended, and no second frame follows. Address changes made during a frame do not alter that frame but are kept for the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench models a PHY that records every bit on each rising MDC edge. On reads, it drives data after each falling edge. This exposes a turnaround released one bit late or early, or an opcode swapped between read and write. A write frame that loses a data bit is also caught. The busy window is counted to the exact cycle, so an off-by-one bit counter shows up as a short or long window. A request and an address change are injected mid-frame: a design that honoured them would restart the frame, run a second frame, or send the changed PHY number. Setting both request bits, or neither, catches a wrong priority and a spurious start.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h214);
  localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'('h218);
  localparam logic [ADDR_W-1:0] OFS_WDAT = ADDR_W'('h21C);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h220);
  localparam logic [ADDR_W-1:0] OFS_RDAT = ADDR_W'('h224);
  localparam int CNT_W    = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int TA_POS   = 46;
  localparam int DATA_POS = 48;
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_HALF - 1);

  logic [4:0]       phy_q, regn_q;
  logic [15:0]      wdat_q, rdat_q, samp_q;
  logic             busy_q, op_rd_q, mdc_q;
  logic [63:0]      shreg_q;
  logic [5:0]       idx_q;
  logic [CNT_W-1:0] div_q;

  wire ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
  wire start   = ctrl_wr && !busy_q && (reg_wdata[3] || reg_wdata[2]);
  wire tick    = busy_q && (div_q == DIV_LAST);
  wire rise    = tick && !mdc_q;
  wire fall    = tick && mdc_q;
  wire last    = fall && (idx_q == 6'd63);

  assign mdc     = mdc_q;
  assign mdio_o  = busy_q ? shreg_q[63] : 1'b1;
  assign mdio_oe = busy_q && !(op_rd_q && (idx_q >= 6'(TA_POS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= '0;
      regn_q <= '0;
      wdat_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_ADDR) begin
        phy_q  <= reg_wdata[12:8];
        regn_q <= reg_wdata[4:0];
      end
      if (reg_addr == OFS_WDAT) wdat_q <= reg_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      mdc_q   <= 1'b0;
      shreg_q <= '1;
      idx_q   <= '0;
      div_q   <= '0;
      samp_q  <= '0;
      rdat_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      op_rd_q <= reg_wdata[3];
      mdc_q   <= 1'b0;
      idx_q   <= '0;
      div_q   <= '0;
      shreg_q <= {32'hFFFF_FFFF, 2'b01,
                  reg_wdata[3] ? 2'b10 : 2'b01,
                  phy_q, regn_q,
                  reg_wdata[3] ? 2'b11 : 2'b10,
                  reg_wdata[3] ? 16'hFFFF : wdat_q};
    end else if (busy_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise && op_rd_q && (idx_q >= 6'(DATA_POS)))
        samp_q <= {samp_q[14:0], mdio_i};
      if (last) begin
        busy_q <= 1'b0;
        if (op_rd_q) rdat_q <= samp_q;
      end else if (fall) begin
        idx_q   <= idx_q + 1'b1;
        shreg_q <= {shreg_q[62:0], 1'b1};
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ADDR: reg_rdata = {19'b0, phy_q, 3'b0, regn_q};
      OFS_WDAT: reg_rdata = {16'b0, wdat_q};
      OFS_STAT: reg_rdata = {31'b0, busy_q};
      OFS_RDAT: reg_rdata = {16'b0, rdat_q};
      default:  reg_rdata = 32'b0;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy_q && (reg_wdata[3] || reg_wdata[2])) |=> busy_q); // R4
  AST_NO_REQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(ctrl_wr && (reg_wdata[3] || reg_wdata[2]))) |=> !busy_q); // R3
  AST_OE_DROP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $fell(mdio_oe)) |-> op_rd_q); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q || !op_rd_q) |=> $stable(rdat_q)); // R6
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$fell(mdc_q)) |-> $stable(mdio_o)); // R7
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctrl_wr) |=> $stable(op_rd_q)); // R8

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int H = 2;
  localparam logic [11:0] A_CTRL = 12'h214, A_ADDR = 12'h218, A_WDAT = 12'h21C,
                          A_STAT = 12'h220, A_RDAT = 12'h224;

  logic clk = 0, rst_n = 0, reg_we = 0, mdio_i = 1;
  logic [11:0] reg_addr = A_STAT;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;

  int checks = 0, fails = 0, idx = 0, period_err = 0;
  logic [63:0] cap, oecap;
  logic [15:0] tb_rd = 0;
  realtime last_rise = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl #(.ADDR_W(12), .DIV_HALF(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    if (idx > 0 && idx < 64 && ($realtime - last_rise) != 4.0 * 2 * H) period_err++;
    last_rise = $realtime;
    if (idx < 64) begin
      cap[63-idx]   = mdio_o;
      oecap[63-idx] = mdio_oe;
    end
    idx++;
  end

  always @(negedge mdc) begin
    if (idx == 47) mdio_i = 1'b0;
    else if (idx >= 48 && idx <= 63) mdio_i = tb_rd[63-idx];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = A_STAT;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [63:0] exp_frame(bit isrd, logic [4:0] p, logic [4:0] r, logic [15:0] w);
    return {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, p, r,
            isrd ? 2'b00 : 2'b10, isrd ? 16'h0 : w};
  endfunction

  task automatic txn(input logic [3:0] ctl, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] w, input logic [15:0] rv, input bit poke);
    logic [31:0] d, prev_rd;
    logic [63:0] ef, mask;
    int n;
    bit isrd;
    isrd = ctl[3];
    wr(A_ADDR, {19'b0, p, 3'b0, r});
    wr(A_WDAT, {16'hABCD, w});
    rd(A_RDAT, prev_rd);
    tb_rd = rv; idx = 0;
    wr(A_CTRL, {28'b0, ctl});
    rd(A_STAT, d);
    chk("R4 busy after request", d, 1);
    n = 0;
    while (n < 4000) begin
      if (poke && n == 100) begin reg_we = 1; reg_addr = A_CTRL; reg_wdata = 32'h8; end
      else if (poke && n == 101) begin reg_we = 1; reg_addr = A_ADDR; reg_wdata = {19'b0, ~p, 3'b0, ~r}; end
      else begin
        reg_we = 0; reg_addr = A_STAT; #1;
        if (!reg_rdata[0]) break;
      end
      @(negedge clk); n++;
    end
    chk("R4 busy duration", n, 128 * H);
    chk("R8 one frame only", idx, 64);
    ef = exp_frame(isrd, p, r, w);
    mask = isrd ? {{46{1'b1}}, 18'b0} : '1;
    chk(isrd ? "R6 read frame header" : "R5 write frame", cap & mask, ef & mask);
    chk(isrd ? "R6 oe released at turnaround" : "R5 oe held", oecap, mask);
    rd(A_RDAT, d);
    chk("R6 read data", d, isrd ? {16'b0, rv} : prev_rd);
    rd(A_CTRL, d);
    chk("R3 control self-clears", d, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk("R8 no restart after ignored request", idx, 64);
      rd(A_ADDR, d);
      chk("R8 address kept for next frame", d, {19'b0, ~p, 3'b0, ~r});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'd7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_STAT, d); chk("R1 status reset", d, 0);
    rd(A_RDAT, d); chk("R1 read data reset", d, 0);
    chk("R1 mdc low", mdc, 0);
    chk("R1 oe low", mdio_oe, 0);

    wr(A_ADDR, 32'hFFFF_FFFF);
    rd(A_ADDR, d); chk("R2 address fields", d, 32'h0000_1F1F);
    wr(A_WDAT, 32'h1234_5678);
    rd(A_WDAT, d); chk("R2 write data", d, 32'h0000_5678);

    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); chk("R3 no request no start", d, 0);
    chk("R3 no frame on empty control", idx, 0);

    txn(4'h4, 5'h01, 5'h00, 16'hA5A5, 16'h0, 0);
    txn(4'h8, 5'h1F, 5'h1F, 16'h0, 16'hFFFF, 0);
    txn(4'h8, 5'h00, 5'h02, 16'h0, 16'h0001, 0);
    txn(4'hC, 5'h05, 5'h11, 16'h0, 16'h8000, 0);
    txn(4'h4, 5'h12, 5'h04, 16'h0000, 16'h0, 1);
    for (int i = 0; i < 14; i++) begin
      logic [4:0] p, r;
      logic [15:0] w, v;
      p = 5'($urandom); r = 5'($urandom); w = 16'($urandom); v = 16'($urandom);
      txn(($urandom % 2) ? 4'h8 : 4'h4, p, r, w, v, 0);
    end

    chk("R7 mdc period", period_err, 0);
    repeat (5) @(negedge clk);
    chk("R7 mdc low when idle", mdc, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule